// File: doc/BRIEF.md
# Predicated Writeback Select Unit

This unit is the last stage of a simple in-order pipeline. It settles conditionally executed instructions at writeback, so the pipeline never has to stall or flush for them. Each instruction arrives with a 4-bit condition code, the result computed for it, and the value its destination register held before. The earlier stages read that prior value as an extra source operand. The instruction also carries a request to update the flags, a store marker with a store-queue tag, and a marker for a load fault.

The unit tests the condition code against the NZCV flags forwarded from the youngest older flag-setting instruction. If the condition passes, it commits the new result and lets every side effect through. If the condition fails, it still performs a register write, but writes back the prior value, so forwarding logic downstream always sees the same kind of write. It also drops the store from the queue, cancels the load fault and masks the flag update. Every output is registered. The unit accepts one instruction per cycle, and its outputs appear one cycle after the instruction is presented.

Top module: `pred_wb_select`

## Requirements
- R1: While reset is held and in the cycle after it, the outputs rf_we, fl_we, st_commit, st_drop and exc_valid are all low.
- R2: An instruction that is valid, passes its condition and has in_wr_dest high gives rf_we=1, rf_addr=in_dest and rf_wdata=in_result one clock later.
- R3: An instruction that is valid, fails its condition and has in_wr_dest high still gives rf_we=1 and rf_addr=in_dest one clock later, with rf_wdata=in_old_val.
- R4: The flags are ordered {N,Z,C,V} on bits [3:0]. The condition codes pass as follows: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V).
- R5: Codes 14 and 15 pass for every flag value.
- R6: One clock after a valid instruction with in_set_flags high that passes, fl_we=1 and fl_wdata=in_new_flags. When the condition fails, fl_we stays 0.
- R7: A valid store that passes gives st_commit=1 and st_drop=0 one clock later. A valid store that fails gives st_drop=1 and st_commit=0. In both cases st_tag equals in_stq_tag, and the two signals are never high together.
- R8: exc_valid is 1 one clock after a valid instruction that has in_load_fault high and passes. A failed condition cancels the fault, and exc_valid stays 0.
- R9: One clock after a cycle with in_valid low, all five enable outputs are low.
- R10: A valid instruction with in_wr_dest low gives rf_we=0, whatever its condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_cond | input | 4 | Condition code |
| in_result | input | DW | Newly computed result |
| in_old_val | input | DW | Prior value of destination register |
| in_dest | input | AW | Destination register index |
| in_wr_dest | input | 1 | Instruction writes a register |
| in_set_flags | input | 1 | Instruction updates flags |
| in_new_flags | input | 4 | Flags the instruction would produce {N,Z,C,V} |
| cur_flags | input | 4 | Forwarded current flags {N,Z,C,V} |
| in_is_store | input | 1 | Instruction is a store |
| in_stq_tag | input | TW | Store-queue entry tag |
| in_load_fault | input | 1 | Load raised a fault |
| rf_we | output | 1 | Register write enable |
| rf_addr | output | AW | Register write index |
| rf_wdata | output | DW | Register write data |
| fl_we | output | 1 | Flag write enable |
| fl_wdata | output | 4 | Flag write value |
| st_commit | output | 1 | Commit store-queue entry |
| st_drop | output | 1 | Drop store-queue entry |
| st_tag | output | TW | Tag for commit or drop |
| exc_valid | output | 1 | Exception raised |

## Verification
A wrong pass/fail decision shows up in the cycle right after the instruction, on every path at once. rf_wdata carries the old value where the result was expected, or the reverse. Store commit and drop change places, and a flag write or an exception appears or goes missing. Because the outputs are registered for a single cycle, a stale or leaked enable is visible on the first idle cycle. The bench sweeps all 256 combinations of code and flag value, and checks each side-effect path under both outcomes.

// File: rtl/pred_wb_pkg.sv
// Package: shared flag layout and condition code values for the
// predicated writeback unit. Assumes flags ordered {N,Z,C,V}.
package pred_wb_pkg;
    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_AX = 4'd15
    } cond_e;

    typedef struct packed {
        logic rf_we;
        logic fl_we;
        logic st_commit;
        logic st_drop;
        logic exc_valid;
    } effects_t;
endpackage

// File: rtl/pwb_cond_eval.sv
// Module: pwb_cond_eval
// Combinational test of a 4-bit condition code against the forwarded
// flags. Assumes the flags are already the youngest older values.
module pwb_cond_eval
    import pred_wb_pkg::*;
(
    input  logic [3:0] cond,
    input  logic [3:0] flags,
    output logic       pass
);
    logic n, z, c, v;
    assign n = flags[FLAG_N];
    assign z = flags[FLAG_Z];
    assign c = flags[FLAG_C];
    assign v = flags[FLAG_V];

    // Decode the condition code into a pass/fail decision.
    always_comb begin
        unique case (cond_e'(cond))
            CC_EQ:   pass = z;
            CC_NE:   pass = !z;
            CC_CS:   pass = c;
            CC_CC:   pass = !c;
            CC_MI:   pass = n;
            CC_PL:   pass = !n;
            CC_VS:   pass = v;
            CC_VC:   pass = !v;
            CC_HI:   pass = c && !z;
            CC_LS:   pass = !c || z;
            CC_GE:   pass = (n == v);
            CC_LT:   pass = (n != v);
            CC_GT:   pass = !z && (n == v);
            CC_LE:   pass = z || (n != v);
            default: pass = 1'b1;
        endcase
    end
endmodule

// File: rtl/pwb_result_select.sv
// Module: pwb_result_select
// Chooses between the new result and the destination's prior value.
// Assumes the prior value was read as an extra operand upstream.
module pwb_result_select #(
    parameter int DW = 32
) (
    input  logic          pass,
    input  logic [DW-1:0] new_val,
    input  logic [DW-1:0] old_val,
    output logic [DW-1:0] sel_val
);
    // Late select: prior value survives a failed condition.
    always_comb begin
        sel_val = pass ? new_val : old_val;
    end
endmodule

// File: rtl/pwb_effect_gate.sv
// Module: pwb_effect_gate
// Builds the next-cycle enables. The register write is kept for
// a failed condition; flag, store and fault effects are masked.
module pwb_effect_gate
    import pred_wb_pkg::*;
(
    input  logic     valid,
    input  logic     pass,
    input  logic     wr_dest,
    input  logic     set_flags,
    input  logic     is_store,
    input  logic     load_fault,
    output effects_t eff
);
    // Gate each side effect by validity and condition outcome.
    always_comb begin
        eff.rf_we     = valid && wr_dest;
        eff.fl_we     = valid && set_flags && pass;
        eff.st_commit = valid && is_store && pass;
        eff.st_drop   = valid && is_store && !pass;
        eff.exc_valid = valid && load_fault && pass;
    end
endmodule

// File: rtl/pred_wb_select.sv
// Module: pred_wb_select (top)
// Resolves predicated instructions at writeback, one per cycle, with
// all outputs registered one cycle after the instruction.
// Assumes cur_flags come from the youngest older flag setter.
module pred_wb_select
    import pred_wb_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 5,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    in_cond,
    input  logic [DW-1:0] in_result,
    input  logic [DW-1:0] in_old_val,
    input  logic [AW-1:0] in_dest,
    input  logic          in_wr_dest,
    input  logic          in_set_flags,
    input  logic [3:0]    in_new_flags,
    input  logic [3:0]    cur_flags,
    input  logic          in_is_store,
    input  logic [TW-1:0] in_stq_tag,
    input  logic          in_load_fault,
    output logic          rf_we,
    output logic [AW-1:0] rf_addr,
    output logic [DW-1:0] rf_wdata,
    output logic          fl_we,
    output logic [3:0]    fl_wdata,
    output logic          st_commit,
    output logic          st_drop,
    output logic [TW-1:0] st_tag,
    output logic          exc_valid
);
    logic          pass;
    logic [DW-1:0] sel_val;
    effects_t      eff_d;
    effects_t      eff_q;

    pwb_cond_eval u_cond (
        .cond  (in_cond),
        .flags (cur_flags),
        .pass  (pass)
    );

    pwb_result_select #(.DW(DW)) u_sel (
        .pass    (pass),
        .new_val (in_result),
        .old_val (in_old_val),
        .sel_val (sel_val)
    );

    pwb_effect_gate u_gate (
        .valid      (in_valid),
        .pass       (pass),
        .wr_dest    (in_wr_dest),
        .set_flags  (in_set_flags),
        .is_store   (in_is_store),
        .load_fault (in_load_fault),
        .eff        (eff_d)
    );

    // Enable register: cleared by reset, reloaded every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) eff_q <= '0;
        else        eff_q <= eff_d;
    end

    // Payload register: loads on a valid instruction, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_addr  <= '0;
            rf_wdata <= '0;
            fl_wdata <= '0;
            st_tag   <= '0;
        end else if (in_valid) begin
            rf_addr  <= in_dest;
            rf_wdata <= sel_val;
            fl_wdata <= in_new_flags;
            st_tag   <= in_stq_tag;
        end
    end

    assign rf_we     = eff_q.rf_we;
    assign fl_we     = eff_q.fl_we;
    assign st_commit = eff_q.st_commit;
    assign st_drop   = eff_q.st_drop;
    assign exc_valid = eff_q.exc_valid;
endmodule

// File: rtl/pred_wb_checker.sv
// Module: pred_wb_checker
// Port-level properties of pred_wb_select, bound onto the top module.
module pred_wb_checker #(
    parameter int DW = 32,
    parameter int AW = 5,
    parameter int TW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [3:0]    in_cond,
    input logic [DW-1:0] in_result,
    input logic [DW-1:0] in_old_val,
    input logic [AW-1:0] in_dest,
    input logic          in_wr_dest,
    input logic          in_set_flags,
    input logic [3:0]    in_new_flags,
    input logic [3:0]    cur_flags,
    input logic          in_is_store,
    input logic [TW-1:0] in_stq_tag,
    input logic          in_load_fault,
    input logic          rf_we,
    input logic [AW-1:0] rf_addr,
    input logic [DW-1:0] rf_wdata,
    input logic          fl_we,
    input logic [3:0]    fl_wdata,
    input logic          st_commit,
    input logic          st_drop,
    input logic [TW-1:0] st_tag,
    input logic          exc_valid
);
    // R2/R5: an always-code write commits the new result at its index.
    p_always_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(in_wr_dest) && $past(in_cond) == 4'd14)
        |-> (rf_we && rf_addr == $past(in_dest) && rf_wdata == $past(in_result)));

    // R3: EQ with Z clear fails, so the prior value is written back.
    p_fail_keeps_old_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(in_wr_dest) && $past(in_cond) == 4'd0
         && !$past(cur_flags[2]))
        |-> (rf_we && rf_wdata == $past(in_old_val)));

    // R6: a flag write carries the instruction's flags.
    p_flag_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |-> (fl_wdata == $past(in_new_flags) && $past(in_set_flags)));

    // R7: never commit and drop together; tag follows the store.
    p_store_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_commit, st_drop}));
    p_store_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_commit || st_drop) |-> (st_tag == $past(in_stq_tag) && $past(in_is_store)));

    // R8: an exception needs a faulting load one cycle earlier.
    p_exc_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> $past(in_load_fault));

    // R9: an idle cycle leaves every enable low.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid))
        |-> !(rf_we || fl_we || st_commit || st_drop || exc_valid));
endmodule

bind pred_wb_select pred_wb_checker #(.DW(DW), .AW(AW), .TW(TW)) u_pred_wb_checker (.*);

// File: tb/pred_wb_select_bench.sv
// Directed bench for pred_wb_select: one task per scenario.
module pred_wb_select_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 5;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [3:0]    in_cond;
    logic [DW-1:0] in_result;
    logic [DW-1:0] in_old_val;
    logic [AW-1:0] in_dest;
    logic          in_wr_dest;
    logic          in_set_flags;
    logic [3:0]    in_new_flags;
    logic [3:0]    cur_flags;
    logic          in_is_store;
    logic [TW-1:0] in_stq_tag;
    logic          in_load_fault;
    logic          rf_we;
    logic [AW-1:0] rf_addr;
    logic [DW-1:0] rf_wdata;
    logic          fl_we;
    logic [3:0]    fl_wdata;
    logic          st_commit;
    logic          st_drop;
    logic [TW-1:0] st_tag;
    logic          exc_valid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pred_wb_select #(.DW(DW), .AW(AW), .TW(TW)) u_pred_wb_select (.*);

    // Expected pass decision taken from R4/R5, flags {N,Z,C,V}.
    function automatic logic exp_pass(input logic [3:0] cc, input logic [3:0] f);
        logic n, z, c, v;
        n = f[3]; z = f[2]; c = f[1]; v = f[0];
        case (cc)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c & !z;
            4'd9:  return !c | z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z & (n == v);
            4'd13: return z | (n != v);
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_valid = 0; in_cond = 4'd14; in_result = '0; in_old_val = '0;
        in_dest = '0; in_wr_dest = 0; in_set_flags = 0; in_new_flags = '0;
        cur_flags = '0; in_is_store = 0; in_stq_tag = '0; in_load_fault = 0;
    endtask

    // Present one instruction at a falling edge; outputs are read one cycle on.
    task automatic issue(input logic [3:0] cc, input logic [3:0] f,
                         input logic wr, input logic sf, input logic st, input logic lf);
        @(negedge clk);
        in_valid = 1; in_cond = cc; cur_flags = f; in_wr_dest = wr;
        in_set_flags = sf; in_is_store = st; in_load_fault = lf;
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic t_reset();
        idle_inputs();
        rst_n = 0;
        in_valid = 1; in_wr_dest = 1; in_is_store = 1; in_set_flags = 1;
        repeat (3) @(negedge clk);
        check("R1", "rf_we in reset", rf_we, 0);
        check("R1", "st enables in reset", {st_commit, st_drop}, 0);
        idle_inputs();
        rst_n = 1;
        @(negedge clk);
        check("R1", "enables after reset", {rf_we, fl_we, st_commit, st_drop, exc_valid}, 0);
    endtask

    task automatic t_pass_fail();
        in_result = 32'hCAFE_0001; in_old_val = 32'h0BAD_0002; in_dest = 5'd17;
        issue(4'd0, 4'b0100, 1, 0, 0, 0);
        check("R2", "rf_we pass", rf_we, 1);
        check("R2", "rf_addr pass", rf_addr, 17);
        check("R2", "rf_wdata pass", rf_wdata, 32'hCAFE_0001);
        in_dest = 5'd3;
        issue(4'd0, 4'b0000, 1, 0, 0, 0);
        check("R3", "rf_we fail", rf_we, 1);
        check("R3", "rf_addr fail", rf_addr, 3);
        check("R3", "rf_wdata fail", rf_wdata, 32'h0BAD_0002);
    endtask

    task automatic t_cond_table();
        in_result = 32'h1111_1111; in_old_val = 32'h2222_2222; in_dest = 5'd9;
        for (int cc = 0; cc < 16; cc++) begin
            for (int f = 0; f < 16; f++) begin
                issue(4'(cc), 4'(f), 1, 0, 0, 0);
                check(cc >= 14 ? "R5" : "R4", $sformatf("code %0d flags %0h", cc, f),
                      rf_wdata, exp_pass(4'(cc), 4'(f)) ? 32'h1111_1111 : 32'h2222_2222);
            end
        end
    endtask

    task automatic t_flags();
        in_new_flags = 4'b1011;
        issue(4'd2, 4'b0010, 0, 1, 0, 0);
        check("R6", "fl_we pass", fl_we, 1);
        check("R6", "fl_wdata", fl_wdata, 4'b1011);
        issue(4'd2, 4'b0000, 0, 1, 0, 0);
        check("R6", "fl_we fail masked", fl_we, 0);
    endtask

    task automatic t_store();
        in_stq_tag = 4'd6;
        issue(4'd10, 4'b1001, 0, 0, 1, 0);
        check("R7", "commit on pass", {st_commit, st_drop}, 2'b10);
        check("R7", "tag on commit", st_tag, 6);
        in_stq_tag = 4'd13;
        issue(4'd10, 4'b1000, 0, 0, 1, 0);
        check("R7", "drop on fail", {st_commit, st_drop}, 2'b01);
        check("R7", "tag on drop", st_tag, 13);
    endtask

    task automatic t_fault();
        issue(4'd15, 4'b0000, 0, 0, 0, 1);
        check("R8", "fault on pass", exc_valid, 1);
        issue(4'd4, 4'b0000, 0, 0, 0, 1);
        check("R8", "fault cancelled", exc_valid, 0);
    endtask

    task automatic t_idle_nowrite();
        issue(4'd14, 4'b0000, 1, 1, 1, 1);
        @(negedge clk);
        check("R9", "idle enables", {rf_we, fl_we, st_commit, st_drop, exc_valid}, 0);
        issue(4'd14, 4'b0000, 0, 0, 0, 0);
        check("R10", "no write pass", rf_we, 0);
        issue(4'd1, 4'b0100, 0, 0, 0, 0);
        check("R10", "no write fail", rf_we, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_pass_fail();
        t_cond_table();
        t_flags();
        t_store();
        t_fault();
        t_idle_nowrite();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule